// File: doc/BRIEF.md
# Multilevel inverter gate sequencer

The block drives the gates of a grid-tied inverter that can produce three, five or seven output levels. The inverter has three parts. The first is a two-switch stage fed by two stacked DC ports: a PV-fed port and an auxiliary port that a booster supplies. The second is a four-switch bridge that sets the output polarity. The third is a dual-inductor booster, which has an enable and a series/parallel mode switch. The block takes one PWM bit from an external carrier comparator, together with sampled magnitudes: the rectified grid voltage, both port voltages, the reference for the PV-port voltage and a setting voltage.

A strobe marks the start of each carrier period. At that strobe the block classifies the port relation (auxiliary below, near, or above the PV port, or PV port above the setting voltage) and the band the grid magnitude sits in. From this it latches a drive code for each stage switch: off, on, follow the PWM, or follow the inverted PWM. The number of output levels therefore changes at run time with the port voltages. Turn-on delays guard complementary stage transitions and bridge polarity changes.

Top module: `mlvl_gate_seq`

## Requirements
- R1: While rst_ni is low, tp_a_o, tp_b_o, bridge_o, boost_mode_o and boost_en_o are all 0. After reset and before the first period strobe, both stage gates stay off.
- R2: If the aux port is below the PV port (and not near it), three bands apply. When the grid magnitude is below aux, tp_a follows PWM and tp_b is off. When it is from aux up to below PV, tp_a follows PWM and tp_b follows inverted PWM. When it is at or above PV, tp_a follows PWM and tp_b is on.
- R3: If the aux port is above the PV port (and not near it), three bands apply. Below PV, tp_a is off and tp_b follows PWM. From PV up to below aux, tp_a follows inverted PWM and tp_b follows PWM. At or above aux, tp_a is on and tp_b follows PWM.
- R4: The ports count as near when |aux - pv| < tol_i. In that case tp_a is off and tp_b follows PWM when the grid magnitude is below PV. At or above PV, tp_a follows PWM and tp_b is on. A difference equal to tol_i is not near.
- R5: When pv > setting_i, this case takes priority over all the others. tp_a is off, tp_b follows PWM, boost_en_o is 0 and boost_mode_o is 0, whatever the aux voltage and the grid magnitude.
- R6: Case, band, boost_en_o and boost_mode_o are taken only at a clock edge where period_start_i is high. Input changes between strobes do not alter the pattern.
- R7: The dead time applies only while the latched pattern is complementary (one gate on PWM, the other on inverted PWM). Each gate's turn-on is then delayed by dead_i clocks, so both gates are off for dead_i clocks at every PWM edge. In any other pattern a gate follows its drive after one register stage.
- R8: bridge_o[0] and bridge_o[3] conduct when grid_pos_i is 1. bridge_o[1] and bridge_o[2] conduct when grid_pos_i is 0. After a polarity change the bridge is all off for dead_i clocks before the new pair turns on.
- R9: boost_mode_o is 1 exactly when the booster is enabled and vpv_ref_i < setting_i/2 (floor).
- R10: A grid magnitude equal to a band edge belongs to the upper band.
- R11: In a complementary pattern tp_a_o and tp_b_o are never high together, and the two bridge pairs are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Carrier-compared PWM bit |
| period_start_i | input | 1 | Carrier period start strobe |
| grid_pos_i | input | 1 | Grid polarity, 1 = positive |
| vgrid_abs_i | input | VW | Rectified grid voltage sample |
| vaux_i | input | VW | Auxiliary (booster-fed) port voltage |
| vpv_i | input | VW | PV-fed port voltage |
| vpv_ref_i | input | VW | PV-port voltage reference |
| setting_i | input | VW | Setting voltage |
| tol_i | input | VW | Near-equal tolerance |
| dead_i | input | DTW | Dead time in clocks |
| tp_a_o | output | 1 | Gate of the aux-port stage switch |
| tp_b_o | output | 1 | Gate of the PV-port stage switch |
| bridge_o | output | 4 | Polarity bridge gates |
| boost_mode_o | output | 1 | Booster inductor series/parallel switch |
| boost_en_o | output | 1 | Booster enable |

## Verification
The assertions assume that dead_i and tol_i are held constant while the block runs, and that period_start_i is a single-clock strobe. The shoot-through and bridge-gap properties are only meaningful under those conditions. The stimulus changes dead_i only between test phases, while the latched pattern is not complementary or the polarity is steady. It pulses the strobe for one clock and holds every voltage sample steady until the pattern has been latched and the gates observed.

// File: rtl/mlvl_gate_seq_pkg.sv
package mlvl_gate_seq_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_ON   = 2'd1,
    DRV_PWM  = 2'd2,
    DRV_NPWM = 2'd3
  } drive_e;

  typedef enum logic [1:0] {
    CASE_AUX_LO = 2'd0,
    CASE_NEAR   = 2'd1,
    CASE_AUX_HI = 2'd2,
    CASE_PV_OVR = 2'd3
  } port_case_e;

  function automatic logic drv_apply(drive_e d, logic pwm);
    case (d)
      DRV_ON:   return 1'b1;
      DRV_PWM:  return pwm;
      DRV_NPWM: return ~pwm;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mlvl_case_sel.sv
module mlvl_case_sel
  import mlvl_gate_seq_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic [VW-1:0] vgrid_abs_i,
  input  logic [VW-1:0] vaux_i,
  input  logic [VW-1:0] vpv_i,
  input  logic [VW-1:0] setting_i,
  input  logic [VW-1:0] tol_i,
  output port_case_e    case_o,
  output drive_e        drv_a_o,
  output drive_e        drv_b_o
);
  logic [VW-1:0] diff;

  always_comb begin
    diff = (vaux_i > vpv_i) ? (vaux_i - vpv_i) : (vpv_i - vaux_i);
    if (vpv_i > setting_i)      case_o = CASE_PV_OVR;
    else if (diff < tol_i)      case_o = CASE_NEAR;
    else if (vaux_i < vpv_i)    case_o = CASE_AUX_LO;
    else                        case_o = CASE_AUX_HI;
  end

  // band edge values fall into the upper band
  always_comb begin
    drv_a_o = DRV_OFF;
    drv_b_o = DRV_PWM;
    unique case (case_o)
      CASE_PV_OVR: begin
        drv_a_o = DRV_OFF;
        drv_b_o = DRV_PWM;
      end
      CASE_NEAR: begin
        if (vgrid_abs_i < vpv_i) begin
          drv_a_o = DRV_OFF;
          drv_b_o = DRV_PWM;
        end else begin
          drv_a_o = DRV_PWM;
          drv_b_o = DRV_ON;
        end
      end
      CASE_AUX_LO: begin
        drv_a_o = DRV_PWM;
        if (vgrid_abs_i < vaux_i)     drv_b_o = DRV_OFF;
        else if (vgrid_abs_i < vpv_i) drv_b_o = DRV_NPWM;
        else                          drv_b_o = DRV_ON;
      end
      default: begin
        drv_b_o = DRV_PWM;
        if (vgrid_abs_i < vpv_i)       drv_a_o = DRV_OFF;
        else if (vgrid_abs_i < vaux_i) drv_a_o = DRV_NPWM;
        else                           drv_a_o = DRV_ON;
      end
    endcase
  end
endmodule

// File: rtl/mlvl_dead_gate.sv
module mlvl_dead_gate #(
  parameter int unsigned DTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           raw_i,
  input  logic [DTW-1:0] dead_i,
  output logic           gate_o
);
  logic [DTW-1:0] run_q;

  // turn-on is delayed by dead_i clocks when enabled; turn-off is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      gate_o <= 1'b0;
    end else begin
      if (!raw_i)              run_q <= '0;
      else if (run_q < dead_i) run_q <= run_q + 1'b1;
      gate_o <= raw_i && (!en_i || (run_q >= dead_i));
    end
  end
endmodule

// File: rtl/mlvl_gate_seq.sv
module mlvl_gate_seq
  import mlvl_gate_seq_pkg::*;
#(
  parameter int unsigned VW  = 12,
  parameter int unsigned DTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pwm_i,
  input  logic           period_start_i,
  input  logic           grid_pos_i,
  input  logic [VW-1:0]  vgrid_abs_i,
  input  logic [VW-1:0]  vaux_i,
  input  logic [VW-1:0]  vpv_i,
  input  logic [VW-1:0]  vpv_ref_i,
  input  logic [VW-1:0]  setting_i,
  input  logic [VW-1:0]  tol_i,
  input  logic [DTW-1:0] dead_i,
  output logic           tp_a_o,
  output logic           tp_b_o,
  output logic [3:0]     bridge_o,
  output logic           boost_mode_o,
  output logic           boost_en_o
);
  localparam int unsigned NG = 4;

  port_case_e case_d;
  drive_e     drv_a_d, drv_b_d;
  drive_e     drv_a_q, drv_b_q;
  logic       comp_q;
  logic       boost_en_q, boost_mode_q;

  mlvl_case_sel #(.VW(VW)) u_case (
    .vgrid_abs_i (vgrid_abs_i),
    .vaux_i      (vaux_i),
    .vpv_i       (vpv_i),
    .setting_i   (setting_i),
    .tol_i       (tol_i),
    .case_o      (case_d),
    .drv_a_o     (drv_a_d),
    .drv_b_o     (drv_b_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_a_q      <= DRV_OFF;
      drv_b_q      <= DRV_OFF;
      comp_q       <= 1'b0;
      boost_en_q   <= 1'b0;
      boost_mode_q <= 1'b0;
    end else if (period_start_i) begin
      drv_a_q      <= drv_a_d;
      drv_b_q      <= drv_b_d;
      comp_q       <= (drv_a_d == DRV_NPWM) || (drv_b_d == DRV_NPWM);
      boost_en_q   <= (case_d != CASE_PV_OVR);
      boost_mode_q <= (case_d != CASE_PV_OVR) && (vpv_ref_i < (setting_i >> 1));
    end
  end

  // gate 0/1: stage switches, gate 2/3: bridge pairs
  logic [NG-1:0] raw, en, gate;
  assign raw = {~grid_pos_i, grid_pos_i,
                drv_apply(drv_b_q, pwm_i), drv_apply(drv_a_q, pwm_i)};
  assign en  = {1'b1, 1'b1, comp_q, comp_q};

  for (genvar g = 0; g < NG; g++) begin : g_gate
    mlvl_dead_gate #(.DTW(DTW)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[g]),
      .raw_i  (raw[g]),
      .dead_i (dead_i),
      .gate_o (gate[g])
    );
  end

  assign tp_a_o       = gate[0];
  assign tp_b_o       = gate[1];
  assign bridge_o     = {gate[2], gate[3], gate[3], gate[2]};
  assign boost_en_o   = boost_en_q;
  assign boost_mode_o = boost_mode_q;
endmodule

// File: rtl/mlvl_gate_seq_chk.sv
module mlvl_gate_seq_chk
  import mlvl_gate_seq_pkg::*;
#(
  parameter int unsigned DTW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           period_start_i,
  input logic [DTW-1:0] dead_i,
  input logic           tp_a_o,
  input logic           tp_b_o,
  input logic [3:0]     bridge_o,
  input logic           boost_mode_o,
  input logic           boost_en_o,
  input logic           comp_q,
  input drive_e         drv_a_q,
  input drive_e         drv_b_q
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !tp_a_o && !tp_b_o && bridge_o == 4'b0 && !boost_mode_o && !boost_en_o);

  p_over_a_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(boost_en_o) |-> !tp_a_o);

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(period_start_i) |-> $stable(drv_a_q) && $stable(drv_b_q) && $stable(boost_en_o));

  p_bridge_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_o[0] == bridge_o[3] && bridge_o[1] == bridge_o[2]);

  p_bridge_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_o[0]) && dead_i != '0 |-> !$past(bridge_o[1]));

  p_mode_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_mode_o |-> boost_en_o);

  p_no_shoot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_a_o && tp_b_o |-> !$past(comp_q));

  p_bridge_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bridge_o[0] && bridge_o[1]));
endmodule

bind mlvl_gate_seq mlvl_gate_seq_chk #(.DTW(DTW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .period_start_i (period_start_i),
  .dead_i         (dead_i),
  .tp_a_o         (tp_a_o),
  .tp_b_o         (tp_b_o),
  .bridge_o       (bridge_o),
  .boost_mode_o   (boost_mode_o),
  .boost_en_o     (boost_en_o),
  .comp_q         (comp_q),
  .drv_a_q        (drv_a_q),
  .drv_b_q        (drv_b_q)
);

// File: tb/tb_mlvl_gate_seq.sv
module tb_mlvl_gate_seq;
  localparam int unsigned VW  = 12;
  localparam int unsigned DTW = 8;
  localparam logic [1:0] D_OFF = 2'd0, D_ON = 2'd1, D_PWM = 2'd2, D_NPWM = 2'd3;

  typedef struct packed {
    logic [VW-1:0] vg;
    logic [VW-1:0] va;
    logic [VW-1:0] vp;
    logic [1:0]    da;
    logic [1:0]    db;
    logic          be;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{12'd30,  12'd60,  12'd120, D_PWM,  D_OFF,  1'b1},  // R2 low band
    '{12'd60,  12'd60,  12'd120, D_PWM,  D_NPWM, 1'b1},  // R2 R10 edge
    '{12'd90,  12'd60,  12'd120, D_PWM,  D_NPWM, 1'b1},  // R2 mid
    '{12'd120, 12'd60,  12'd120, D_PWM,  D_ON,   1'b1},  // R2 R10 edge
    '{12'd150, 12'd60,  12'd120, D_PWM,  D_ON,   1'b1},  // R2 high
    '{12'd30,  12'd120, 12'd60,  D_OFF,  D_PWM,  1'b1},  // R3 low
    '{12'd60,  12'd120, 12'd60,  D_NPWM, D_PWM,  1'b1},  // R3 R10 edge
    '{12'd100, 12'd120, 12'd60,  D_NPWM, D_PWM,  1'b1},  // R3 mid
    '{12'd150, 12'd120, 12'd60,  D_ON,   D_PWM,  1'b1},  // R3 high
    '{12'd50,  12'd91,  12'd90,  D_OFF,  D_PWM,  1'b1},  // R4 low
    '{12'd90,  12'd91,  12'd90,  D_PWM,  D_ON,   1'b1},  // R4 high
    '{12'd91,  12'd92,  12'd90,  D_NPWM, D_PWM,  1'b1},  // R4 diff == tol
    '{12'd150, 12'd200, 12'd181, D_OFF,  D_PWM,  1'b0},  // R5
    '{12'd10,  12'd10,  12'd181, D_OFF,  D_PWM,  1'b0},  // R5
    '{12'd10,  12'd0,   12'd180, D_PWM,  D_NPWM, 1'b1}   // R5 boundary not over
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm = 1'b0, pstart = 1'b0, gpos = 1'b1;
  logic [VW-1:0] vg = '0, va = '0, vp = '0, vref = 12'd100;
  logic [VW-1:0] setting = 12'd180, tol = 12'd2;
  logic [DTW-1:0] dead = '0;
  logic tp_a, tp_b, bmode, ben;
  logic [3:0] bridge;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mlvl_gate_seq #(.VW(VW), .DTW(DTW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .period_start_i(pstart),
    .grid_pos_i(gpos), .vgrid_abs_i(vg), .vaux_i(va), .vpv_i(vp),
    .vpv_ref_i(vref), .setting_i(setting), .tol_i(tol), .dead_i(dead),
    .tp_a_o(tp_a), .tp_b_o(tp_b), .bridge_o(bridge),
    .boost_mode_o(bmode), .boost_en_o(ben)
  );

  function automatic logic exp_gate(logic [1:0] d, logic p);
    case (d)
      D_ON:   return 1'b1;
      D_PWM:  return p;
      D_NPWM: return ~p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic latch(logic [VW-1:0] g, logic [VW-1:0] a, logic [VW-1:0] p);
    @(negedge clk);
    vg = g; va = a; vp = p; pstart = 1'b1;
    @(negedge clk);
    pstart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {2'b0, tp_a, tp_b, bridge}, 8'h00);
    chk("R1 reset boost", {6'b0, bmode, ben}, 8'h00);
    rst_ni = 1'b1;
    pwm = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no strobe yet", {6'b0, tp_a, tp_b}, 8'h00);
    chk("R8 positive pair", {4'b0, bridge}, 8'h09);

    // table
    for (int i = 0; i < NV; i++) begin
      pwm = 1'b1;
      latch(VECS[i].vg, VECS[i].va, VECS[i].vp);
      @(negedge clk);
      chk($sformatf("R2-5 vec%0d pwm1", i), {6'b0, tp_a, tp_b},
          {6'b0, exp_gate(VECS[i].da, 1'b1), exp_gate(VECS[i].db, 1'b1)});
      pwm = 1'b0;
      @(negedge clk);
      chk($sformatf("R2-5 vec%0d pwm0", i), {6'b0, tp_a, tp_b},
          {6'b0, exp_gate(VECS[i].da, 1'b0), exp_gate(VECS[i].db, 1'b0)});
      chk($sformatf("R5 R9 vec%0d boost", i), {6'b0, bmode, ben}, {7'b0, VECS[i].be});
    end

    // R9 mode switch
    vref = 12'd89;
    latch(12'd30, 12'd60, 12'd120);
    chk("R9 ref below half", {7'b0, bmode}, 8'h01);
    vref = 12'd90;
    latch(12'd30, 12'd60, 12'd120);
    chk("R9 ref at half", {7'b0, bmode}, 8'h00);
    vref = 12'd10;
    latch(12'd30, 12'd60, 12'd181);
    chk("R5 R9 over forces mode off", {6'b0, bmode, ben}, 8'h00);
    vref = 12'd100;

    // R6 latch only at strobe
    pwm = 1'b0;
    latch(12'd150, 12'd60, 12'd120);
    @(negedge clk);
    chk("R6 high band b on", {7'b0, tp_b}, 8'h01);
    vg = 12'd30;
    repeat (3) @(negedge clk);
    chk("R6 no change mid period", {7'b0, tp_b}, 8'h01);
    latch(12'd30, 12'd60, 12'd120);
    @(negedge clk);
    chk("R6 change after strobe", {7'b0, tp_b}, 8'h00);

    // R7 dead time in complementary band
    dead = 8'd3;
    pwm = 1'b1;
    latch(12'd90, 12'd60, 12'd120);
    repeat (5) @(negedge clk);
    chk("R7 a on before edge", {6'b0, tp_a, tp_b}, 8'h02);
    pwm = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R7 R11 gap after fall", {6'b0, tp_a, tp_b}, 8'h00);
    end
    @(negedge clk);
    chk("R7 b on after gap", {6'b0, tp_a, tp_b}, 8'h01);
    pwm = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R7 R11 gap after rise", {6'b0, tp_a, tp_b}, 8'h00);
    end
    @(negedge clk);
    chk("R7 a on after gap", {6'b0, tp_a, tp_b}, 8'h02);

    // R7 no delay outside complementary pattern
    pwm = 1'b0;
    latch(12'd30, 12'd60, 12'd120);
    repeat (2) @(negedge clk);
    pwm = 1'b1;
    @(negedge clk);
    chk("R7 no delay in non-comp", {6'b0, tp_a, tp_b}, 8'h02);

    // R8 bridge polarity gap
    gpos = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R8 bridge gap", {4'b0, bridge}, 8'h00);
    end
    @(negedge clk);
    chk("R8 negative pair", {4'b0, bridge}, 8'h06);
    gpos = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 back positive", {4'b0, bridge}, 8'h09);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule